// File: doc/BRIEF.md
# Byte-wide one-time-programmable memory mode model

This block is a synthesizable, cycle-based model of a byte-wide memory whose cells can only be programmed from 1 to 0. It is intended as a target device for testbenches of device programmers and bus controllers. All pin levels are reduced to digital flags:
- a chip-select `ce_n`;
- an output-enable level `oe_n`;
- a "programming supply raised" flag `vpp_hi`, which shares its role with the output enable;
- an "identifier voltage on address bit 9" flag `id_hv`.

The block drives a data byte together with an output-enable for an external tri-state buffer.

Each clock edge, the sampled control flags select one of seven named states of a mode machine:

| State | Selected when |
|---|---|
| `ST_STANDBY` | chip deselected, supply low |
| `ST_INHIBIT` | chip deselected, supply raised |
| `ST_PROG` | selected, supply raised, no ID voltage |
| `ST_MARGIN` | selected, supply raised, ID voltage |
| `ST_OUT_DIS` | selected, output enable high |
| `ST_READ` | selected, output enable low |
| `ST_SIG` | selected, output enable low, ID voltage |

Transitions are taken every cycle from any state to the decoded one. Two transitions have side effects:
- Entering `ST_PROG` from any other state performs one AND-write of the data input into the addressed byte.
- Leaving `ST_MARGIN` while the supply and ID flags stay raised latches address bit 10 into the margin flag.

The array depth is a parameter, and upper address bits alias onto it. At reset every byte becomes 0xFF, the erased state.

Top module: `otp_prom`

## Requirements
- R1: After reset every array byte reads 0xFF, `dout_oe` is 0, `margin_on` is 0 and `proto_err` is 0.
- R2: With `ce_n`=0, `vpp_hi`=0, `oe_n`=0 and `id_hv`=0 sampled at an edge, after that edge `dout_oe`=1 and `dout` equals the byte at index `addr[IDX_W-1:0]`; higher address bits are ignored.
- R3: With `ce_n`=1 sampled at an edge, `dout_oe` is 0 after that edge whatever `oe_n`, `vpp_hi` and `id_hv` are.
- R4: With `ce_n`=0, `vpp_hi`=0 and `oe_n`=1, `dout_oe` is 0 after the edge.
- R5: The first edge at which `ce_n`=0, `vpp_hi`=1 and `id_hv`=0 follow a cycle in another state replaces the addressed byte with (old byte AND `din`). `dout_oe` stays 0 for as long as `vpp_hi` is sampled 1. With `ce_n`=1 and `vpp_hi`=1, nothing is written.
- R6: With `ce_n`=0, `vpp_hi`=0, `oe_n`=0, `id_hv`=1 and all address bits other than bit 0 and bit 9 zero, the output after the edge is 0x20 when `addr[0]`=0 and 0x42 when `addr[0]`=1, with `dout_oe`=1.
- R7: In the identifier read of R6, if any address bit other than bit 0 and bit 9 is 1, the output is 0xFF with `dout_oe`=1 and `proto_err`=1. `proto_err` is 0 in every other case.
- R8: Consider an edge where `ce_n`=1, `vpp_hi`=1 and `id_hv`=1 follow a cycle with `ce_n`=0 under the same two flags. At that edge `margin_on` takes `addr[10]`, so 1 sets it and 0 resets it. `margin_on` changes at no other edge.
- R9: A chip-select low cycle with `vpp_hi`=1 and `id_hv`=1 writes nothing. Programming never turns a 0 bit into 1, so writing 0xFF leaves a byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, erases the array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable level, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identifier voltage present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Data out |
| dout_oe | output | 1 | Drive enable for the external data buffer |
| margin_on | output | 1 | Latched margin mode flag |
| proto_err | output | 1 | Identifier read with illegal address bits |

## Verification
Every output result is due one edge after the inputs are sampled: the state, the array read word and the identifier byte are all registered at the same edge, and the outputs are decoded from them. An array write lands at the edge that enters `ST_PROG`, so it becomes visible on a read issued at any later edge. The margin flag changes at the edge that leaves `ST_MARGIN`. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. Each check therefore reads the value produced by exactly one edge. The array sweeps recompute their expected bytes arithmetically from the address.

// File: rtl/otp_prom_pkg.sv
package otp_prom_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_INHIBIT,
        ST_PROG,
        ST_MARGIN,
        ST_OUT_DIS,
        ST_READ,
        ST_SIG
    } prom_state_t;

    // Mode decode shared by the state machine; supply flag overrides the
    // output-enable level because both share one pin.
    function automatic prom_state_t decode_mode(
        input logic ce_n,
        input logic oe_n,
        input logic vpp_hi,
        input logic id_hv
    );
        prom_state_t m;
        if (ce_n) begin
            m = vpp_hi ? ST_INHIBIT : ST_STANDBY;
        end else if (vpp_hi) begin
            m = id_hv ? ST_MARGIN : ST_PROG;
        end else if (oe_n) begin
            m = ST_OUT_DIS;
        end else begin
            m = id_hv ? ST_SIG : ST_READ;
        end
        return m;
    endfunction

endpackage

// File: rtl/prom_mode_fsm.sv
module prom_mode_fsm
    import otp_prom_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        vpp_hi,
    input  logic        id_hv,
    input  logic        margin_sel,
    output prom_state_t state,
    output logic        wr_pulse,
    output logic        margin_on
);

    prom_state_t state_nx;
    logic        margin_exit;

    always_comb begin
        state_nx = decode_mode(ce_n, oe_n, vpp_hi, id_hv);
    end

    // One write per chip-select pulse: only on entry into ST_PROG.
    always_comb begin
        wr_pulse = (state_nx == ST_PROG) && (state != ST_PROG);
    end

    // Rising chip select with supply and ID voltage still raised.
    always_comb begin
        margin_exit = (state == ST_MARGIN) && ce_n && vpp_hi && id_hv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STANDBY;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            margin_on <= 1'b0;
        end else if (margin_exit) begin
            margin_on <= margin_sel;
        end
    end

endmodule

// File: rtl/prom_byte_array.sv
module prom_byte_array
    import otp_prom_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '1;
        end else begin
            rdata <= cells[idx];
        end
    end

endmodule

// File: rtl/prom_sig_rom.sv
module prom_sig_rom
    import otp_prom_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [BYTE_W-1:0] MFG_CODE = 8'h20,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] code,
    output logic              bad_addr
);

    localparam logic [ADDR_W-1:0] ALLOWED = ADDR_W'(1) | (ADDR_W'(1) << 9);

    logic stray;

    always_comb begin
        stray = |(addr & ~ALLOWED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code     <= '1;
            bad_addr <= 1'b0;
        end else begin
            bad_addr <= stray;
            if (stray) begin
                code <= '1;
            end else begin
                code <= addr[0] ? DEV_CODE : MFG_CODE;
            end
        end
    end

endmodule

// File: rtl/otp_prom.sv
module otp_prom
    import otp_prom_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe,
    output logic              margin_on,
    output logic              proto_err
);

    prom_state_t       state;
    logic              wr_pulse;
    logic [BYTE_W-1:0] arr_q;
    logic [BYTE_W-1:0] sig_q;
    logic              sig_bad;

    prom_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .vpp_hi     (vpp_hi),
        .id_hv      (id_hv),
        .margin_sel (addr[10]),
        .state      (state),
        .wr_pulse   (wr_pulse),
        .margin_on  (margin_on)
    );

    prom_byte_array #(.IDX_W(IDX_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_pulse),
        .idx   (addr[IDX_W-1:0]),
        .wdata (din),
        .rdata (arr_q)
    );

    prom_sig_rom #(.ADDR_W(ADDR_W)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .code     (sig_q),
        .bad_addr (sig_bad)
    );

    always_comb begin
        dout      = '0;
        dout_oe   = 1'b0;
        proto_err = 1'b0;
        unique case (state)
            ST_READ: begin
                dout    = arr_q;
                dout_oe = 1'b1;
            end
            ST_SIG: begin
                dout      = sig_q;
                dout_oe   = 1'b1;
                proto_err = sig_bad;
            end
            ST_STANDBY, ST_INHIBIT, ST_PROG, ST_MARGIN, ST_OUT_DIS: begin
                dout    = '0;
                dout_oe = 1'b0;
            end
            default: begin
                dout    = '0;
                dout_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/otp_prom_chk.sv
module otp_prom_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_oe,
    input logic              margin_on,
    input logic              proto_err
);

    localparam logic [ADDR_W-1:0] KEEP = ADDR_W'(1) | (ADDR_W'(1) << 9);

    logic clean;
    assign clean = ~|(addr & ~KEEP);

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && !oe_n) |=> dout_oe); // R2
    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_oe); // R3
    AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && oe_n) |=> !dout_oe); // R4
    AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_hi |=> !dout_oe); // R5
    AST_SIG_MFG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && !oe_n && id_hv && clean && !addr[0]) |=> (dout == 8'h20)); // R6
    AST_SIG_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !vpp_hi && !oe_n && id_hv && clean && addr[0]) |=> (dout == 8'h42)); // R6
    AST_ERR_FF: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (dout_oe && dout == 8'hFF)); // R7
    AST_MARGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(vpp_hi && id_hv && ce_n) |=> $stable(margin_on)); // R8

endmodule

bind otp_prom otp_prom_chk #(.ADDR_W(ADDR_W)) u_otp_prom_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .vpp_hi    (vpp_hi),
    .id_hv     (id_hv),
    .addr      (addr),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .margin_on (margin_on),
    .proto_err (proto_err)
);

// File: tb/test_otp_prom.sv
module test_otp_prom;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int IDX_W      = 5;
    localparam int DEPTH      = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              vpp_hi = 1'b0;
    logic              id_hv = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_oe;
    logic              margin_on;
    logic              proto_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_otp_prom (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .id_hv(id_hv), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .margin_on(margin_on), .proto_err(proto_err)
    );

    function automatic logic [7:0] pat_a(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] pat_b(int a);
        return 8'(~(a * 5 + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #1;
    endtask

    task automatic set_in(logic c, logic o, logic v, logic i, logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_hi = v; id_hv = i; addr = a; din = d;
    endtask

    task automatic read_chk(string req, logic [ADDR_W-1:0] a, logic [7:0] exp);
        set_in(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
        edge_sample();
        check(req, {dout_oe, dout}, {1'b1, exp});
    endtask

    task automatic prog(logic [ADDR_W-1:0] a, logic [7:0] d);
        set_in(1'b1, 1'b1, 1'b1, 1'b0, a, d);
        edge_sample();
        set_in(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        edge_sample();
        check("R5 hiz in pulse", dout_oe, 0);
        set_in(1'b0, 1'b1, 1'b1, 1'b0, a, d);
        edge_sample();
        set_in(1'b1, 1'b1, 1'b1, 1'b0, a, d);
        edge_sample();
        set_in(1'b1, 1'b1, 1'b0, 1'b0, a, d);
        edge_sample();
    endtask

    task automatic margin_cycle(logic bit10, logic [7:0] d);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(bit10) << 10;
        set_in(1'b1, 1'b1, 1'b1, 1'b1, a, d);
        edge_sample();
        set_in(1'b0, 1'b1, 1'b1, 1'b1, a, d);
        edge_sample();
        check("R8 held while E low", margin_on, !bit10);
        set_in(1'b1, 1'b1, 1'b1, 1'b1, a, d);
        edge_sample();
        check("R8 latched at E rise", margin_on, bit10);
        set_in(1'b1, 1'b1, 1'b0, 1'b0, '0, 8'h00);
        edge_sample();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 oe after reset", dout_oe, 0);
        check("R1 margin after reset", margin_on, 0);
        check("R1 err after reset", proto_err, 0);

        for (int a = 0; a < DEPTH; a++) read_chk("R1 erased byte", ADDR_W'(a), 8'hFF);

        // R3 standby over every oe/vpp/id combination
        for (int k = 0; k < 8; k++) begin
            set_in(1'b1, k[0], k[1], k[2], '0, 8'h00);
            edge_sample();
            check("R3 standby hiz", dout_oe, 0);
        end
        set_in(1'b0, 1'b1, 1'b0, 1'b0, '0, 8'h00);
        edge_sample();
        check("R4 output disable", dout_oe, 0);
        set_in(1'b0, 1'b1, 1'b0, 1'b1, '0, 8'h00);
        edge_sample();
        check("R4 output disable with id", dout_oe, 0);

        for (int a = 0; a < DEPTH; a++) prog(ADDR_W'(a), pat_a(a));
        for (int a = 0; a < DEPTH; a++) read_chk("R5 first program", ADDR_W'(a), pat_a(a));
        for (int a = 0; a < DEPTH; a++) prog(ADDR_W'(a), pat_b(a));
        for (int a = 0; a < DEPTH; a++)
            read_chk("R2 aliased read of AND", ADDR_W'(a + (a % 7 + 1) * DEPTH), pat_a(a) & pat_b(a));

        // R9 writing all ones leaves byte
        prog(ADDR_W'(3), 8'hFF);
        read_chk("R9 no bit set", ADDR_W'(3), pat_a(3) & pat_b(3));

        // R5 inhibit: E high, supply raised, zero data
        set_in(1'b1, 1'b1, 1'b1, 1'b0, ADDR_W'(4), 8'h00);
        edge_sample();
        set_in(1'b1, 1'b1, 1'b1, 1'b0, ADDR_W'(4), 8'h00);
        edge_sample();
        read_chk("R5 inhibit no write", ADDR_W'(4), pat_a(4) & pat_b(4));

        // R6 identifier codes
        set_in(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(0), 8'h00);
        edge_sample();
        check("R6 mfg code", {dout_oe, proto_err, dout}, {2'b10, 8'h20});
        set_in(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(1), 8'h00);
        edge_sample();
        check("R6 dev code", {dout_oe, proto_err, dout}, {2'b10, 8'h42});
        set_in(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(1) | (ADDR_W'(1) << 9), 8'h00);
        edge_sample();
        check("R6 bit9 allowed", {dout_oe, proto_err, dout}, {2'b10, 8'h42});

        // R7 each stray bit
        for (int b = 1; b < ADDR_W; b++) begin
            if (b != 9) begin
                set_in(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(1) << b, 8'h00);
                edge_sample();
                check("R7 stray bit", {dout_oe, proto_err, dout}, {2'b11, 8'hFF});
            end
        end
        read_chk("R7 err clear on read", ADDR_W'(2), pat_a(2) & pat_b(2));
        check("R7 err low on read", proto_err, 0);

        // R8 set and reset; R9 margin pulse writes nothing
        margin_cycle(1'b1, 8'h00);
        read_chk("R9 margin pulse no write", ADDR_W'(0), pat_a(0) & pat_b(0));
        set_in(1'b1, 1'b1, 1'b0, 1'b1, '0, 8'h00);
        edge_sample();
        check("R8 no change without supply", margin_on, 1);
        margin_cycle(1'b0, 8'h00);
        read_chk("R9 margin reset no write", ADDR_W'(0), pat_a(0) & pat_b(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule